// File: doc/BRIEF.md
# Cartridge ROM page mapper

This block sits between the CPU's memory strobes and a ROM cartridge of up to thirty-two 16 KB pages. It drives the upper five cartridge address lines, the cartridge chip-enable, a select for the on-chip memory-mapped register page, and a select telling the RAM that it answers the access. The CPU address is given to the block as its two top bits, which name one of four 16 KB quarters of the 64 KB map.

Two registers set the mapping. The high-bank select register is written through its own I/O strobe and picks the page seen at C000h. Values of 128 and above give the page directly. Values below 128 give either the BASIC page or the disk page, and the disk page is chosen when the value equals the current disk code. A secondary low-bank register is written through the mode port. It can only be written while the feature lock is open, and it places the low ROM in one of three quarters or opens the register page at 4000h. It also selects one of the first eight pages for the low ROM. Two legacy disable bits in the mode port and an external disable input switch the ROM windows off. Writes into a ROM window always go to the RAM below it. The register page never passes writes to RAM.

Top module: `rom_page_mapper`

## Requirements
- R1: Synchronous reset clears all outputs to 0, the high-bank select to 0, the low-bank register to 0 (low ROM at 0000h, page 0) and both legacy disable bits. A read at C000h right after reset with disk_alt=0 therefore returns page 3 with chip-enable.
- R2: A high-bank select value of 128 or more makes a C000h read return its bits 4:0 as cart_page.
- R3: A high-bank select value below 128 makes a C000h read return page 1. When the value equals the disk code (0 when disk_alt=0, 7 when disk_alt=1), the read returns page 3.
- R4: A mode-port write with data bits 7:5 = 101 while unlock=1 loads data bits 4:0 into the low-bank register. Bits 2:0 are the low-bank page, and a read in the low window returns {00, bits 2:0}.
- R5: Low-bank register bits 4:3 = 00, 01, 10 place the low ROM at 0000h, 4000h or 8000h. A read in any other quarter below C000h goes to RAM (ram_sel=1).
- R6: Bits 4:3 = 11 place the low ROM at 0000h and open the register page at 4000h–7FFFh. Reads and writes there assert reg_sel only.
- R7: With unlock=0, a mode-port write with bits 7:5 = 101 leaves the low-bank register unchanged and is taken as a legacy write. A mode-port write whose bits 7:6 are not 10 changes nothing.
- R8: A legacy write (bits 7:6 = 10, and not a secondary write) sets the low-ROM disable from data bit 2 and the high-ROM disable from data bit 3. A disabled window, wherever it is placed, answers reads with ram_sel.
- R9: ext_rom_dis=1 turns off the C000h window, the disk page included, so the read goes to RAM. The low window is not affected.
- R10: A write never asserts cart_ce. A write into a ROM window or into RAM asserts ram_sel, and a write into the open register page asserts reg_sel with ram_sel=0.
- R11: Outputs are registered. The result of an access presented in one cycle appears after the next rising edge. With no strobe, all outputs are 0, and cart_page is 0 whenever cart_ce is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_top | input | 2 | CPU address bits 15:14 |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_wr_hi | input | 1 | Write strobe of the high-bank select port |
| io_wr_mode | input | 1 | Write strobe of the mode port |
| io_data | input | 8 | Data for port writes |
| unlock | input | 1 | Feature lock open |
| ext_rom_dis | input | 1 | External ROM disable |
| disk_alt | input | 1 | Disk code select: 0 means code 0, 1 means code 7 |
| cart_page | output | 5 | Upper cartridge address lines |
| cart_ce | output | 1 | Cartridge chip-enable |
| reg_sel | output | 1 | Register page select |
| ram_sel | output | 1 | RAM answers the access |

## Verification
A memory access presented in one cycle is due on the outputs one rising edge later. A port write takes effect at its own edge, so an access in the next cycle sees the new mapping. The bench drives inputs on the falling edge, applies only one operation per cycle, and samples one time unit after the following rising edge. At that point it compares all four outputs against a model of the two registers and the disable bits, and that model is updated in the same order as the writes. Directed cases cover each window placement, each disable and both disk codes. A fixed-seed random mix of writes and accesses then exercises the priorities between windows.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  localparam int PAGE_W     = 5;
  localparam int LOW_PAGE_W = 3;
  localparam int DATA_W     = 8;

  typedef enum logic [1:0] {
    PLACE_Q0    = 2'b00,
    PLACE_Q1    = 2'b01,
    PLACE_Q2    = 2'b10,
    PLACE_REGPG = 2'b11
  } low_place_e;

  typedef struct packed {
    low_place_e            place;
    logic [LOW_PAGE_W-1:0] page;
  } low_map_t;
endpackage

// File: rtl/rpm_regs.sv
module rpm_regs
  import rpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr_hi,
  input  logic              io_wr_mode,
  input  logic [DATA_W-1:0] io_data,
  input  logic              unlock,
  output logic [DATA_W-1:0] hi_sel,
  output low_map_t          low_map,
  output logic              lo_dis,
  output logic              hi_dis
);
  logic sec_hit, legacy_hit;
  logic unused_mode_bits;

  assign sec_hit    = io_wr_mode && unlock && (io_data[7:5] == 3'b101);
  assign legacy_hit = io_wr_mode && !sec_hit && (io_data[7:6] == 2'b10);
  assign unused_mode_bits = ^{io_data[4], io_data[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_sel  <= '0;
      low_map <= '{place: PLACE_Q0, page: '0};
      lo_dis  <= 1'b0;
      hi_dis  <= 1'b0;
    end else begin
      if (io_wr_hi)
        hi_sel <= io_data;
      if (sec_hit)
        low_map <= low_map_t'(io_data[4:0]);
      if (legacy_hit) begin
        lo_dis <= io_data[2];
        hi_dis <= io_data[3];
      end
    end
  end
endmodule

// File: rtl/rpm_hipage.sv
module rpm_hipage
  import rpm_pkg::*;
#(
  parameter logic [DATA_W-1:0] DISK_CODE_A = 8'd0,
  parameter logic [DATA_W-1:0] DISK_CODE_B = 8'd7,
  parameter logic [PAGE_W-1:0] BASIC_PAGE  = 5'd1,
  parameter logic [PAGE_W-1:0] DISK_PAGE   = 5'd3
) (
  input  logic [DATA_W-1:0] hi_sel,
  input  logic              disk_alt,
  output logic [PAGE_W-1:0] hi_page
);
  logic [DATA_W-1:0] disk_code;

  assign disk_code = disk_alt ? DISK_CODE_B : DISK_CODE_A;

  always_comb begin
    if (hi_sel[DATA_W-1])
      hi_page = hi_sel[PAGE_W-1:0];
    else if (hi_sel == disk_code)
      hi_page = DISK_PAGE;
    else
      hi_page = BASIC_PAGE;
  end
endmodule

// File: rtl/rpm_decode.sv
module rpm_decode
  import rpm_pkg::*;
#(
  parameter int NQ = 4
) (
  input  logic [$clog2(NQ)-1:0] quarter,
  input  logic                  rd,
  input  logic                  wr,
  input  low_map_t              low_map,
  input  logic                  lo_dis,
  input  logic                  hi_dis,
  input  logic                  ext_dis,
  input  logic [PAGE_W-1:0]     hi_page,
  output logic                  ce,
  output logic [PAGE_W-1:0]     page,
  output logic                  regs,
  output logic                  ram
);
  localparam int QW = $clog2(NQ);
  localparam logic [QW-1:0] REG_Q  = QW'(1);
  localparam logic [QW-1:0] HIGH_Q = QW'(NQ-1);

  logic [QW-1:0] low_q;
  logic          regpg_on;
  logic [NQ-1:0] low_hit;
  logic          in_reg, lo_en, hi_en;

  assign regpg_on = (low_map.place == PLACE_REGPG);
  assign low_q    = regpg_on ? '0 : QW'(low_map.place);

  genvar q;
  generate
    for (q = 0; q < NQ; q++) begin : g_quarter
      assign low_hit[q] = (quarter == QW'(q)) && (low_q == QW'(q));
    end
  endgenerate

  assign in_reg = regpg_on && (quarter == REG_Q);
  assign lo_en  = (|low_hit) && !lo_dis;
  assign hi_en  = (quarter == HIGH_Q) && !hi_dis && !ext_dis;

  always_comb begin
    ce   = 1'b0;
    page = '0;
    regs = 1'b0;
    ram  = 1'b0;
    if (rd) begin
      if (in_reg) begin
        regs = 1'b1;
      end else if (lo_en) begin
        ce   = 1'b1;
        page = {{(PAGE_W-LOW_PAGE_W){1'b0}}, low_map.page};
      end else if (hi_en) begin
        ce   = 1'b1;
        page = hi_page;
      end else begin
        ram = 1'b1;
      end
    end else if (wr) begin
      if (in_reg)
        regs = 1'b1;
      else
        ram = 1'b1;
    end
  end
endmodule

// File: rtl/rom_page_mapper.sv
module rom_page_mapper
  import rpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr_top,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              io_wr_hi,
  input  logic              io_wr_mode,
  input  logic [DATA_W-1:0] io_data,
  input  logic              unlock,
  input  logic              ext_rom_dis,
  input  logic              disk_alt,
  output logic [PAGE_W-1:0] cart_page,
  output logic              cart_ce,
  output logic              reg_sel,
  output logic              ram_sel
);
  logic [DATA_W-1:0] hi_sel;
  low_map_t          low_map;
  logic              lo_dis, hi_dis;
  logic [PAGE_W-1:0] hi_page, nx_page;
  logic              nx_ce, nx_reg, nx_ram;

  rpm_regs u_regs (
    .clk(clk), .rst(rst), .io_wr_hi(io_wr_hi), .io_wr_mode(io_wr_mode),
    .io_data(io_data), .unlock(unlock), .hi_sel(hi_sel), .low_map(low_map),
    .lo_dis(lo_dis), .hi_dis(hi_dis)
  );

  rpm_hipage u_hipage (
    .hi_sel(hi_sel), .disk_alt(disk_alt), .hi_page(hi_page)
  );

  rpm_decode #(.NQ(4)) u_decode (
    .quarter(addr_top), .rd(mem_rd), .wr(mem_wr), .low_map(low_map),
    .lo_dis(lo_dis), .hi_dis(hi_dis), .ext_dis(ext_rom_dis),
    .hi_page(hi_page), .ce(nx_ce), .page(nx_page), .regs(nx_reg), .ram(nx_ram)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cart_page <= '0;
      cart_ce   <= 1'b0;
      reg_sel   <= 1'b0;
      ram_sel   <= 1'b0;
    end else begin
      cart_page <= nx_page;
      cart_ce   <= nx_ce;
      reg_sel   <= nx_reg;
      ram_sel   <= nx_ram;
    end
  end
endmodule

// File: rtl/rpm_checker.sv
module rpm_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] addr_top,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       ext_rom_dis,
  input logic [4:0] cart_page,
  input logic       cart_ce,
  input logic       reg_sel,
  input logic       ram_sel
);
  // R10, R11: chip-enable only follows a read
  a_r10_ce_needs_read: assert property (@(posedge clk) disable iff (rst)
    cart_ce |-> $past(mem_rd));

  // R10: a write never enables the cartridge
  a_r10_write_no_ce: assert property (@(posedge clk) disable iff (rst)
    $past(mem_wr) && !$past(mem_rd) |-> !cart_ce);

  // R6: register page select only in the 4000h quarter
  a_r6_reg_quarter: assert property (@(posedge clk) disable iff (rst)
    reg_sel |-> ($past(addr_top) == 2'b01));

  // R9: external disable keeps the C000h quarter off the cartridge
  a_r9_ext_blocks_high: assert property (@(posedge clk) disable iff (rst)
    $past(ext_rom_dis) && ($past(addr_top) == 2'b11) |-> !cart_ce);

  // R11: at most one responder, and no page without chip-enable
  a_r11_one_responder: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cart_ce, reg_sel, ram_sel}));

  a_r11_page_zero_idle: assert property (@(posedge clk) disable iff (rst)
    !cart_ce |-> (cart_page == 5'd0));
endmodule

bind rom_page_mapper rpm_checker chk_i (.*);

// File: tb/rom_page_mapper_tb_top.sv
module rom_page_mapper_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] addr_top;
  logic       mem_rd, mem_wr, io_wr_hi, io_wr_mode, unlock, ext_rom_dis, disk_alt;
  logic [7:0] io_data;
  logic [4:0] cart_page;
  logic       cart_ce, reg_sel, ram_sel;

  int total = 0;
  int bad = 0;

  logic [7:0] m_hi;
  logic [4:0] m_low;
  logic       m_lodis, m_hidis;

  always #2 clk = ~clk;

  rom_page_mapper dut_i (.*);

  function automatic logic [7:0] expect_out(input logic [1:0] q, input logic rd,
                                            input logic wr, input logic ext,
                                            input logic dalt);
    logic [4:0] hp;
    logic [1:0] lq;
    logic       rp;
    rp = (m_low[4:3] == 2'b11);
    lq = rp ? 2'b00 : m_low[4:3];
    if (m_hi[7])                             hp = m_hi[4:0];
    else if (m_hi == (dalt ? 8'd7 : 8'd0))   hp = 5'd3;
    else                                     hp = 5'd1;
    // packed as {ce, reg, ram, page}
    if (rd) begin
      if (rp && q == 2'b01)                 return {3'b010, 5'd0};
      else if (q == lq && !m_lodis)         return {3'b100, 2'b00, m_low[2:0]};
      else if (q == 2'b11 && !m_hidis && !ext) return {3'b100, hp};
      else                                  return {3'b001, 5'd0};
    end else if (wr) begin
      if (rp && q == 2'b01)                 return {3'b010, 5'd0};
      else                                  return {3'b001, 5'd0};
    end
    return 8'd0;
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    logic [7:0] got;
    got = {cart_ce, reg_sel, ram_sel, cart_page};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got ce/reg/ram/page=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    mem_rd = 0; mem_wr = 0; io_wr_hi = 0; io_wr_mode = 0; io_data = 0;
    ext_rom_dis = 0; addr_top = 0;
  endtask

  task automatic wr_hi(input logic [7:0] d);
    @(negedge clk); idle_inputs(); io_wr_hi = 1; io_data = d;
    @(posedge clk); #1; m_hi = d;
  endtask

  task automatic wr_mode(input logic [7:0] d, input logic ul);
    @(negedge clk); idle_inputs(); io_wr_mode = 1; io_data = d; unlock = ul;
    @(posedge clk); #1;
    if (ul && d[7:5] == 3'b101) m_low = d[4:0];
    else if (d[7:6] == 2'b10) begin m_lodis = d[2]; m_hidis = d[3]; end
  endtask

  task automatic access(input string tag, input logic [1:0] q, input logic rd,
                        input logic wr, input logic ext, input logic dalt);
    logic [7:0] e;
    @(negedge clk); idle_inputs();
    addr_top = q; mem_rd = rd; mem_wr = wr; ext_rom_dis = ext; disk_alt = dalt;
    e = expect_out(q, rd, wr, ext, dalt);
    @(posedge clk); #1;
    check(tag, e);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    idle_inputs(); unlock = 0; disk_alt = 0; rst = 1;
    m_hi = 0; m_low = 0; m_lodis = 0; m_hidis = 0;
    repeat (3) @(posedge clk);
    #1; check("R1 reset outputs", 8'd0);
    @(negedge clk); rst = 0;

    access("R1 reset high disk page", 2'b11, 1, 0, 0, 0);
    if (cart_page !== 5'd3) begin bad++; $display("FAIL R1: got page %0d expected 3", cart_page); end
    total++;
    access("R1 reset low page0", 2'b00, 1, 0, 0, 0);
    wr_hi(8'h85); access("R2 page 5", 2'b11, 1, 0, 0, 0);
    wr_hi(8'h9F); access("R2 page 31", 2'b11, 1, 0, 0, 0);
    wr_hi(8'h07); access("R3 code7 disk", 2'b11, 1, 0, 0, 1);
    access("R3 code0 basic", 2'b11, 1, 0, 0, 0);
    wr_hi(8'h7F); access("R3 basic 7F", 2'b11, 1, 0, 0, 1);
    wr_mode(8'hAE, 1); access("R4 R5 low at 4000 page6", 2'b01, 1, 0, 0, 0);
    access("R5 0000 now RAM", 2'b00, 1, 0, 0, 0);
    wr_mode(8'hB2, 1); access("R5 low at 8000 page2", 2'b10, 1, 0, 0, 0);
    wr_mode(8'hBB, 1); access("R6 low at 0000 page3", 2'b00, 1, 0, 0, 0);
    access("R6 reg page read", 2'b01, 1, 0, 0, 0);
    access("R6 R10 reg page write", 2'b01, 0, 1, 0, 0);
    access("R10 write through ROM", 2'b00, 0, 1, 0, 0);
    wr_mode(8'hA4, 0); access("R7 R8 locked write to legacy", 2'b00, 1, 0, 0, 0);
    access("R7 reg page kept", 2'b01, 1, 0, 0, 0);
    wr_mode(8'h48, 1); access("R7 bad select ignored", 2'b00, 1, 0, 0, 0);
    wr_mode(8'h88, 0); access("R8 high disabled", 2'b11, 1, 0, 0, 0);
    access("R8 low back on", 2'b00, 1, 0, 0, 0);
    wr_mode(8'h80, 0); wr_hi(8'h00);
    access("R9 ext blocks disk page", 2'b11, 1, 0, 1, 0);
    access("R9 low unaffected", 2'b00, 1, 0, 1, 0);
    access("R11 idle", 2'b11, 0, 0, 0, 0);

    for (int i = 0; i < 800; i++) begin
      int op;
      op = $urandom_range(0, 5);
      if (op == 0)
        wr_hi(($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 1) * 7) : 8'($urandom()));
      else if (op == 1)
        wr_mode({2'b10, 1'($urandom_range(0, 1)), 5'($urandom())}, 1'($urandom_range(0, 1)));
      else
        access("R11 random access", 2'($urandom()), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule